// File: doc/BRIEF.md
# Cascaded Dual Eight-Line Interrupt Controller

This block joins two eight-line interrupt controllers into one sixteen-line unit. The upstream controller talks to the processor. The downstream controller feeds its request into upstream line 2. Each controller keeps four per-line registers: pending requests, lines in service, a mask, and a trigger select that chooses edge or level. Each controller also has a rotating priority origin, a vector base and three mode bits. The processor sees a single request wire, `cpu_int`. It answers with a one-cycle acknowledge strobe. One cycle later the block returns an 8-bit vector equal to base plus line, together with the global line number.

Line priority is rotating. The search starts at the controller's rotation origin and wraps around the eight lines. A controller offers a request only if its best unmasked pending line ranks strictly above its best in-service line. A non-specific end-of-interrupt command retires the highest-ranked in-service line. Automatic end-of-interrupt can replace that command. It can also move the rotation origin to the line just past the one acknowledged. A special nested option lets the upstream controller ignore its own in-service cascade line, so that a more urgent downstream request can still interrupt. When nothing deliverable remains at acknowledge time, line 7 of the responding controller is returned as a spurious vector.

Top module: `pic_cascade_pair`

## Requirements
- R1: With trigger bit = 1 (level), a line's pending bit follows the input: high sets it, and low clears it one cycle later.
- R2: With trigger bit = 0 (edge), only a 0-to-1 input change sets the pending bit. A low input leaves a latched request in place. An input held high after acknowledge does not request again.
- R3: The priority search begins at the rotation origin (reset 0) and wraps modulo 8. The first pending unmasked line found wins.
- R4: `cpu_int` is high only when a controller has an unmasked pending line that ranks strictly above its best in-service line. A mask bit of 1 blocks its line, and a blocked request is kept for later.
- R5: An acknowledge while `cpu_int` is high does four things. It marks the winning line in service. It clears that line's pending bit only in edge mode. One cycle later it raises `ack_done` for one cycle. It also drives `ack_vector` to base plus line and `ack_line` to the global line.
- R6: An end-of-interrupt pulse (`eoi_we`, unit chosen by `eoi_unit`) clears the highest-ranked in-service bit of that unit.
- R7: Mode bit 0 (automatic end-of-interrupt) leaves the in-service bits unchanged on acknowledge. When mode bit 1 is also set, the rotation origin becomes line + 1 modulo 8.
- R8: A deliverable downstream request reaches upstream line 2 as a pulse, so upstream line 2 must stay in edge mode. Acknowledging upstream line 2 also acknowledges the downstream winner and returns downstream base + line, with `ack_line` = 8 + line. Input `irq_i[2]` is ignored.
- R9: When upstream mode bit 2 (special nested) is set, the upstream controller leaves in-service line 2 out of its current-priority rank.
- R10: An acknowledge with no upstream request returns upstream base + 7 and `ack_line` 7. An acknowledge of upstream line 2 when the downstream has nothing deliverable returns downstream base + 7 and `ack_line` 15.
- R11: After reset, `cpu_int` and `ack_done` are low. All masks are 0, all lines are edge-triggered and all modes are 0. The bases are 0x20 upstream and 0x28 downstream. Configuration writes use `cfg_unit` (0 upstream, 1 downstream) and `cfg_addr`: 0 mask, 1 trigger, 2 base, 3 mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| irq_i | input | 16 | Request lines; [7:0] upstream, [15:8] downstream |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_unit | input | 1 | Controller selected for the write |
| cfg_addr | input | 2 | Register code (mask, trigger, base, mode) |
| cfg_data | input | 8 | Write data |
| eoi_we | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_unit | input | 1 | Controller receiving the end-of-interrupt |
| ack_req | input | 1 | Processor acknowledge strobe |
| cpu_int | output | 1 | Interrupt request to the processor |
| ack_done | output | 1 | Acknowledge result valid, one cycle after the strobe |
| ack_vector | output | 8 | Vector returned by the acknowledge |
| ack_line | output | 4 | Global line acknowledged (downstream = 8 + line) |

## Verification
The in-line properties run on every clock. They watch each pending bit follow its level input or hold its edge latch. They check that a delivered request always has an unmasked pending line behind it. They check that acknowledge sets the in-service bit, or leaves all in-service bits unchanged under automatic end-of-interrupt. They also check the one-cycle `ack_done` timing and the spurious upstream line. Some behaviour can only be shown through scenarios: priority order after rotation, blocking by a line in service, cascade forwarding and its special nested relief, and the downstream spurious vector. The bench covers these with acknowledge sequences whose vectors it predicts from the requirements.

// File: rtl/pic_pkg.sv
package pic_pkg;
   localparam int VEC_W = 8;

   typedef enum logic [1:0] {
      CFG_MASK = 2'd0,
      CFG_TRIG = 2'd1,
      CFG_BASE = 2'd2,
      CFG_MODE = 2'd3
   } cfg_addr_e;

   typedef struct packed {
      logic nest_skip;   // bit 2
      logic rot_on_auto; // bit 1
      logic auto_eoi;    // bit 0
   } mode_t;
endpackage

// File: rtl/pic_prio_scan.sv
module pic_prio_scan #(
   parameter int NLINES = 8,
   localparam int LW = $clog2(NLINES)
) (
   input  logic [NLINES-1:0] mask_i,
   input  logic [LW-1:0]     rot_i,
   output logic [LW:0]       rank_o
);
   // rank NLINES means nothing set; lower rank wins
   always_comb begin
      rank_o = (LW+1)'(NLINES);
      for (int i = NLINES - 1; i >= 0; i--) begin
         if (mask_i[LW'(rot_i + LW'(i))]) rank_o = (LW+1)'(i);
      end
   end
endmodule

// File: rtl/pic_req_bit.sv
module pic_req_bit #(
   parameter bit CASCADE = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic level_mode_i,
   input  logic clr_i,
   output logic req_o
);
   logic req_q;
   assign req_o = req_q;

   generate
      if (CASCADE) begin : g_cas
         // pulse input: high then low within the cycle
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) req_q <= 1'b0;
            else if (level_mode_i) req_q <= 1'b0;
            else req_q <= (req_q & ~clr_i) | lvl_i;
         end
      end else begin : g_pin
         logic last_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               req_q  <= 1'b0;
               last_q <= 1'b0;
            end else begin
               last_q <= lvl_i;
               if (level_mode_i) req_q <= lvl_i;
               else req_q <= (req_q & ~clr_i) | (lvl_i & ~last_q);
            end
         end

         // R1
         level_low_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (level_mode_i && !lvl_i) |=> !req_o);
         // R2
         edge_latch_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!level_mode_i && req_o && !clr_i) |=> req_o);
         // R2
         edge_low_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!level_mode_i && !req_o && !lvl_i) |=> !req_o);
      end
   endgenerate
endmodule

// File: rtl/pic_cell.sv
module pic_cell
   import pic_pkg::*;
#(
   parameter int               NLINES    = 8,
   parameter bit               IS_MASTER = 1'b0,
   parameter int               CAS_LINE  = 2,
   parameter logic [VEC_W-1:0] BASE_RST  = 8'h20,
   localparam int              LW        = $clog2(NLINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NLINES-1:0] lvl_i,
   input  logic              cfg_we_i,
   input  cfg_addr_e         cfg_addr_i,
   input  logic [VEC_W-1:0]  cfg_data_i,
   input  logic              eoi_i,
   input  logic              ack_i,
   output logic              int_o,
   output logic [LW-1:0]     line_o,
   output logic [VEC_W-1:0]  base_o
);
   initial begin
      assert (NLINES >= 2 && (1 << LW) == NLINES && NLINES <= VEC_W)
         else $fatal(1, "pic_cell: NLINES must be a power of two in 2..VEC_W");
      assert (CAS_LINE >= 0 && CAS_LINE < NLINES)
         else $fatal(1, "pic_cell: CAS_LINE out of range");
   end

   logic [NLINES-1:0] imr_q, trig_q, isr_q, isr_view, req, clr, pick_oh, eoi_oh;
   logic [VEC_W-1:0]  base_q;
   mode_t             mode_q;
   logic [LW-1:0]     rot_q, eoi_line;
   logic [LW:0]       req_rank, cur_rank, eoi_rank;
   logic              ack_take, eoi_hit;

   // request bits, cascade input gets the pulse variant
   for (genvar j = 0; j < NLINES; j++) begin : g_line
      localparam bit IS_CAS = IS_MASTER && (j == CAS_LINE);
      pic_req_bit #(.CASCADE(IS_CAS)) u_bit (
         .clk          (clk),
         .rst_n        (rst_n),
         .lvl_i        (lvl_i[j]),
         .level_mode_i (trig_q[j]),
         .clr_i        (clr[j]),
         .req_o        (req[j])
      );
   end

   generate
      if (IS_MASTER) begin : g_nest
         always_comb begin
            isr_view = isr_q;
            if (mode_q.nest_skip) isr_view[CAS_LINE] = 1'b0;
         end
      end else begin : g_plain
         assign isr_view = isr_q;
      end
   endgenerate

   pic_prio_scan #(.NLINES(NLINES)) u_req (.mask_i(req & ~imr_q), .rot_i(rot_q), .rank_o(req_rank));
   pic_prio_scan #(.NLINES(NLINES)) u_cur (.mask_i(isr_view),     .rot_i(rot_q), .rank_o(cur_rank));
   pic_prio_scan #(.NLINES(NLINES)) u_eoi (.mask_i(isr_q),        .rot_i(rot_q), .rank_o(eoi_rank));

   assign int_o    = (req_rank < cur_rank);
   assign line_o   = rot_q + req_rank[LW-1:0];
   assign base_o   = base_q;
   assign ack_take = ack_i && int_o;
   assign pick_oh  = NLINES'(1) << line_o;
   assign eoi_line = rot_q + eoi_rank[LW-1:0];
   assign eoi_hit  = eoi_i && (eoi_rank != (LW+1)'(NLINES));
   assign eoi_oh   = eoi_hit ? (NLINES'(1) << eoi_line) : '0;
   assign clr      = ack_take ? (pick_oh & ~trig_q) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         imr_q  <= '0;
         trig_q <= '0;
         base_q <= BASE_RST;
         mode_q <= '0;
      end else if (cfg_we_i) begin
         case (cfg_addr_i)
            CFG_MASK: imr_q  <= cfg_data_i[NLINES-1:0];
            CFG_TRIG: trig_q <= cfg_data_i[NLINES-1:0];
            CFG_BASE: base_q <= cfg_data_i;
            default:  mode_q <= mode_t'(cfg_data_i[2:0]);
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         isr_q <= '0;
         rot_q <= '0;
      end else begin
         isr_q <= (isr_q & ~eoi_oh) | ((ack_take && !mode_q.auto_eoi) ? pick_oh : '0);
         if (ack_take && mode_q.auto_eoi && mode_q.rot_on_auto)
            rot_q <= line_o + LW'(1);
      end
   end

   // R4
   int_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int_o |-> ((req & ~imr_q) != '0));
   // R5
   ack_sets_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && !mode_q.auto_eoi && !eoi_i) |=> isr_q[$past(line_o)]);
   // R7
   auto_eoi_service_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_take && mode_q.auto_eoi && !eoi_i) |=> $stable(isr_q));
   // R11
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_we_i |=> $stable(mode_q));
endmodule

// File: rtl/pic_cascade_pair.sv
module pic_cascade_pair
   import pic_pkg::*;
#(
   parameter int               NLINES      = 8,
   parameter int               CAS_LINE    = 2,
   parameter logic [VEC_W-1:0] MASTER_BASE = 8'h20,
   parameter logic [VEC_W-1:0] SLAVE_BASE  = 8'h28,
   localparam int              LW          = $clog2(NLINES),
   localparam int              GW          = $clog2(2 * NLINES)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*NLINES-1:0] irq_i,
   input  logic                cfg_we,
   input  logic                cfg_unit,
   input  logic [1:0]          cfg_addr,
   input  logic [VEC_W-1:0]    cfg_data,
   input  logic                eoi_we,
   input  logic                eoi_unit,
   input  logic                ack_req,
   output logic                cpu_int,
   output logic                ack_done,
   output logic [VEC_W-1:0]    ack_vector,
   output logic [GW-1:0]       ack_line
);
   localparam logic [LW-1:0] SPUR = LW'(NLINES - 1);

   logic [NLINES-1:0] m_lvl;
   logic              m_int, s_int, s_ack;
   logic [LW-1:0]     m_line, s_line;
   logic [VEC_W-1:0]  m_base, s_base;
   cfg_addr_e         addr;

   assign addr = cfg_addr_e'(cfg_addr);

   // cascade pulse held off during an acknowledge so a just-served
   // downstream request is not forwarded twice
   always_comb begin
      m_lvl           = irq_i[NLINES-1:0];
      m_lvl[CAS_LINE] = s_int & ~ack_req;
   end

   assign s_ack = ack_req && m_int && (m_line == LW'(CAS_LINE));

   pic_cell #(.NLINES(NLINES), .IS_MASTER(1'b1), .CAS_LINE(CAS_LINE), .BASE_RST(MASTER_BASE)) u_master (
      .clk(clk), .rst_n(rst_n), .lvl_i(m_lvl),
      .cfg_we_i(cfg_we && !cfg_unit), .cfg_addr_i(addr), .cfg_data_i(cfg_data),
      .eoi_i(eoi_we && !eoi_unit), .ack_i(ack_req),
      .int_o(m_int), .line_o(m_line), .base_o(m_base)
   );

   pic_cell #(.NLINES(NLINES), .IS_MASTER(1'b0), .CAS_LINE(CAS_LINE), .BASE_RST(SLAVE_BASE)) u_slave (
      .clk(clk), .rst_n(rst_n), .lvl_i(irq_i[2*NLINES-1:NLINES]),
      .cfg_we_i(cfg_we && cfg_unit), .cfg_addr_i(addr), .cfg_data_i(cfg_data),
      .eoi_i(eoi_we && eoi_unit), .ack_i(s_ack),
      .int_o(s_int), .line_o(s_line), .base_o(s_base)
   );

   assign cpu_int = m_int;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_done   <= 1'b0;
         ack_vector <= '0;
         ack_line   <= '0;
      end else begin
         ack_done <= ack_req;
         if (ack_req) begin
            if (!m_int) begin
               ack_vector <= m_base + VEC_W'(SPUR);
               ack_line   <= GW'(SPUR);
            end else if (m_line == LW'(CAS_LINE)) begin
               if (s_int) begin
                  ack_vector <= s_base + VEC_W'(s_line);
                  ack_line   <= GW'(NLINES) + GW'(s_line);
               end else begin
                  ack_vector <= s_base + VEC_W'(SPUR);
                  ack_line   <= GW'(NLINES) + GW'(SPUR);
               end
            end else begin
               ack_vector <= m_base + VEC_W'(m_line);
               ack_line   <= GW'(m_line);
            end
         end
      end
   end

   // R5
   ack_done_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_req |=> ack_done);
   // R5
   ack_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_req |=> !ack_done);
   // R10
   spurious_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_req && !cpu_int) |=> (ack_line == GW'(SPUR)));
endmodule

// File: tb/sim_pic_cascade_pair.sv
module sim_pic_cascade_pair;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] irq_i = '0;
   logic        cfg_we = 1'b0, cfg_unit = 1'b0;
   logic [1:0]  cfg_addr = '0;
   logic [7:0]  cfg_data = '0;
   logic        eoi_we = 1'b0, eoi_unit = 1'b0, ack_req = 1'b0;
   logic        cpu_int, ack_done;
   logic [7:0]  ack_vector;
   logic [3:0]  ack_line;

   int checks = 0, fails = 0;
   logic [11:0] expq [$];
   string       tagq [$];

   always #2 clk = ~clk;

   pic_cascade_pair u0 (
      .clk(clk), .rst_n(rst_n), .irq_i(irq_i), .cfg_we(cfg_we), .cfg_unit(cfg_unit),
      .cfg_addr(cfg_addr), .cfg_data(cfg_data), .eoi_we(eoi_we), .eoi_unit(eoi_unit),
      .ack_req(ack_req), .cpu_int(cpu_int), .ack_done(ack_done),
      .ack_vector(ack_vector), .ack_line(ack_line)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic cfg(input logic unit, input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_unit = unit; cfg_addr = a; cfg_data = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic eoi(input logic unit);
      @(negedge clk);
      eoi_we = 1'b1; eoi_unit = unit;
      @(negedge clk);
      eoi_we = 1'b0;
   endtask

   // driver: pushes the expected result, then strobes
   task automatic do_ack(input string req, input logic [7:0] vec, input logic [3:0] line);
      @(negedge clk);
      expq.push_back({vec, line});
      tagq.push_back(req);
      ack_req = 1'b1;
      @(negedge clk);
      ack_req = 1'b0;
   endtask

   // monitor: pops and compares as results appear
   always @(negedge clk) begin
      if (rst_n && ack_done) begin
         if (expq.size() == 0) begin
            checks++; fails++;
            $display("FAIL R5 unexpected ack_done actual=%0h expected=none", {ack_vector, ack_line});
         end else begin
            logic [11:0] e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, {ack_vector, ack_line}, e);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(1);
      // R11 reset state
      check("R11 cpu_int", cpu_int, 0);
      check("R11 ack_done", ack_done, 0);
      do_ack("R10 master spurious", 8'h27, 4'd7);

      // R2 edge latch on line 0
      irq_i[0] = 1'b1; wait_cyc(2);
      check("R2 edge sets", cpu_int, 1);
      irq_i[0] = 1'b0; wait_cyc(2);
      check("R2 low keeps latch", cpu_int, 1);
      do_ack("R5 line0", 8'h20, 4'd0);
      wait_cyc(1);
      check("R5 edge pending cleared", cpu_int, 0);
      irq_i[0] = 1'b1; wait_cyc(2);
      check("R4 blocked by in-service", cpu_int, 0);
      eoi(1'b0); wait_cyc(1);
      check("R6 eoi releases", cpu_int, 1);
      do_ack("R5 line0 again", 8'h20, 4'd0);
      eoi(1'b0); wait_cyc(2);
      check("R2 held high no rerequest", cpu_int, 0);
      irq_i[0] = 1'b0;

      // R1 level on line 3
      cfg(1'b0, 2'd1, 8'h08);
      irq_i[3] = 1'b1; wait_cyc(2);
      check("R1 level high", cpu_int, 1);
      irq_i[3] = 1'b0; wait_cyc(2);
      check("R1 level low clears", cpu_int, 0);
      irq_i[3] = 1'b1; wait_cyc(2);
      do_ack("R5 line3 level", 8'h23, 4'd3);
      wait_cyc(1);
      check("R5 level blocked by service", cpu_int, 0);
      eoi(1'b0); wait_cyc(1);
      check("R5 level pending kept", cpu_int, 1);
      irq_i[3] = 1'b0; wait_cyc(2);
      check("R1 level drop", cpu_int, 0);
      cfg(1'b0, 2'd1, 8'h00);

      // R3 fixed order at origin 0, R4 mask
      irq_i[5] = 1'b1; irq_i[1] = 1'b1; wait_cyc(2);
      do_ack("R3 line1 first", 8'h21, 4'd1);
      wait_cyc(1);
      check("R4 lower rank blocked", cpu_int, 0);
      eoi(1'b0);
      do_ack("R3 line5 next", 8'h25, 4'd5);
      eoi(1'b0);
      irq_i[5] = 1'b0; irq_i[1] = 1'b0;
      cfg(1'b0, 2'd0, 8'h10);
      irq_i[4] = 1'b1; wait_cyc(2);
      check("R4 masked", cpu_int, 0);
      cfg(1'b0, 2'd0, 8'h00); wait_cyc(1);
      check("R4 unmask releases", cpu_int, 1);
      do_ack("R4 line4", 8'h24, 4'd4);
      eoi(1'b0);
      irq_i[4] = 1'b0;

      // R7 automatic eoi with rotation, R3 rotated search
      cfg(1'b0, 2'd3, 8'h03);
      irq_i[6] = 1'b1; wait_cyc(2);
      do_ack("R7 line6", 8'h26, 4'd6);
      irq_i[6] = 1'b0;
      irq_i[1] = 1'b1; irq_i[7] = 1'b1; wait_cyc(2);
      do_ack("R3 origin7 picks line7", 8'h27, 4'd7);
      do_ack("R7 no service kept line1", 8'h21, 4'd1);
      cfg(1'b0, 2'd3, 8'h00);
      irq_i[1] = 1'b0; irq_i[7] = 1'b0;
      irq_i[0] = 1'b1; irq_i[3] = 1'b1; wait_cyc(2);
      do_ack("R3 origin2 picks line3", 8'h23, 4'd3);
      wait_cyc(1);
      check("R3 line0 ranks below line3", cpu_int, 0);
      eoi(1'b0);
      do_ack("R3 line0 last", 8'h20, 4'd0);
      eoi(1'b0);
      irq_i[0] = 1'b0; irq_i[3] = 1'b0;

      // R8 cascade
      irq_i[2] = 1'b1; wait_cyc(3);
      check("R8 irq2 ignored", cpu_int, 0);
      irq_i[2] = 1'b0;
      irq_i[10] = 1'b1; wait_cyc(3);
      check("R8 cascade raises", cpu_int, 1);
      do_ack("R8 slave line2", 8'h2A, 4'd10);
      eoi(1'b1); eoi(1'b0);
      irq_i[10] = 1'b0;

      // R9 special nested
      irq_i[12] = 1'b1; wait_cyc(3);
      do_ack("R8 slave line4", 8'h2C, 4'd12);
      irq_i[9] = 1'b1; wait_cyc(3);
      check("R9 nested off blocks", cpu_int, 0);
      cfg(1'b0, 2'd3, 8'h04); wait_cyc(1);
      check("R9 nested on passes", cpu_int, 1);
      do_ack("R9 slave line1", 8'h29, 4'd9);
      eoi(1'b1); eoi(1'b1); eoi(1'b0);
      cfg(1'b0, 2'd3, 8'h00);
      irq_i[12] = 1'b0; irq_i[9] = 1'b0;
      wait_cyc(2);
      check("R6 all retired", cpu_int, 0);

      // R10 slave spurious
      irq_i[11] = 1'b1; wait_cyc(3);
      cfg(1'b1, 2'd0, 8'h08); wait_cyc(2);
      check("R10 cascade latch held", cpu_int, 1);
      do_ack("R10 slave spurious", 8'h2F, 4'd15);
      eoi(1'b0);
      cfg(1'b1, 2'd0, 8'h00); wait_cyc(3);
      do_ack("R8 slave line3 after unmask", 8'h2B, 4'd11);
      eoi(1'b1); eoi(1'b0);
      irq_i[11] = 1'b0;

      // R5 base write
      cfg(1'b0, 2'd2, 8'h40); wait_cyc(2);
      do_ack("R5 new base spurious", 8'h47, 4'd7);
      wait_cyc(3);
      check("R5 scoreboard drained", expq.size(), 0);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule